// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the entry half of exception handling for a small 32-bit core. The core presents four request lines at once: a maskable hardware interrupt, a non-maskable interrupt, a software break/trap and a bus fault. Alongside them it presents its current program counter, delay-slot indicator, status word, stack pointers and exception base address. While idle, the block accepts the most urgent eligible request and captures that context. It then walks a fixed sequence, and each step drives one group of write strobes back into the core's register file.

The sequence has four steps after acceptance. The save step writes the return address, rewound when the exception hit a delay slot, and writes the vector index into an exception information word. The shift step pushes the mode flags in the status word and, in user mode, swaps the user and kernel stack pointers. The fetch step reads the handler address from the vector table in code memory and waits for the memory's valid handshake. The final step writes that address into the program counter. Requests that arrive while a sequence runs are not taken. A second bus fault during a bus-fault entry raises a sticky error flag.

Top module: `exc_entry_seq`

## Requirements
- R1: When several eligible requests are present in an idle cycle, exactly one is accepted, in this priority order: bus fault, then break/trap, then NMI, then interrupt. In the cycle after acceptance, `ack` pulses for one cycle with a single bit set: bit 3 for bus fault, bit 2 for break, bit 1 for NMI, bit 0 for interrupt.
- R2: An interrupt is eligible only when status bit 4 (interrupt enable) is 1 and `irq_lock` is 0. An NMI is eligible only when status bit 9 (NMI enable) is 1. Break and bus fault are always eligible. An ineligible request produces no `ack`.
- R3: The vector is `fault_vec` for a bus fault, `trap_vec` for a break, `irq_vec` for an interrupt and 0 for an NMI. In the `ack` cycle, `exc_info` carries the vector in bits [15:8] with all other bits zero, and `exc_info_we` is high.
- R4: In the `ack` cycle, `ret_addr` holds the return address. An NMI strobes `nrp_we` only. Every other source strobes `erp_we` only.
- R5: If `in_dslot` was 1 at acceptance, `ret_addr` is `cur_pc` minus 2 and `dslot_clr` pulses in the `ack` cycle. Otherwise `ret_addr` equals `cur_pc` and `dslot_clr` stays low.
- R6: In the cycle after `ack`, if status bit 8 (user mode) was 1, `stack_we` is high with `usp_out` equal to the captured `cur_sp` and `sp_out` equal to the captured `kern_sp`. If that bit was 0, `stack_we` stays low.
- R7: In the cycle after `ack`, `status_we` is high and `status_out` equals ((s & 0xC000_0000) | ((s << 12) >> 2)) & ~0x3FF. Here s is the captured status, with bit 9 cleared first when the source is an NMI.
- R8: The next cycle `mem_req` rises with `mem_addr` = `vec_base` + vector*4. Request and address hold until `mem_valid` is seen. In the following cycle, `pc_we` and `done` are high with `pc_out` equal to the returned `mem_rdata`.
- R9: A request raised while a sequence is in progress is not accepted, neither then nor after the sequence ends unless it is raised again.
- R10: `req_bus` high during a bus-fault sequence after its acceptance sets `recursive_fault`, which stays set until reset. Other requests during a sequence do not set it.
- R11: While `rst` is high, and in the first cycle after reset, `ack`, `mem_req`, `done`, every write strobe and `recursive_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_irq | input | 1 | Maskable interrupt request |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_brk | input | 1 | Break/trap request |
| req_bus | input | 1 | Bus fault request |
| irq_lock | input | 1 | Blocks interrupt acceptance when high |
| irq_vec | input | 8 | Vector from the interrupt controller |
| trap_vec | input | 8 | Vector for break/trap |
| fault_vec | input | 8 | Vector for bus fault |
| cur_pc | input | 32 | Current program counter |
| in_dslot | input | 1 | Exception hit a delay slot |
| cur_status | input | 32 | Current status word |
| cur_sp | input | 32 | Current stack pointer |
| kern_sp | input | 32 | Saved kernel stack pointer |
| vec_base | input | 32 | Vector table base address |
| mem_req | output | 1 | Code-memory read request |
| mem_addr | output | 32 | Code-memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ack | output | 4 | One-hot accepted source |
| ret_addr | output | 32 | Return address to save |
| erp_we | output | 1 | Write exception return register |
| nrp_we | output | 1 | Write NMI return register |
| exc_info | output | 32 | Exception information word |
| exc_info_we | output | 1 | Write exception information word |
| dslot_clr | output | 1 | Clear delay-slot indicator |
| stack_we | output | 1 | Write both stack pointers |
| usp_out | output | 32 | New user stack pointer |
| sp_out | output | 32 | New stack pointer |
| status_out | output | 32 | New status word |
| status_we | output | 1 | Write status word |
| pc_out | output | 32 | Handler address |
| pc_we | output | 1 | Write program counter |
| done | output | 1 | Sequence complete |
| recursive_fault | output | 1 | Sticky recursive bus-fault flag |

## Verification
The properties assume that `mem_valid` arrives only while `mem_req` is high. They also assume the core's context inputs are stable in the acceptance cycle. The bench's memory responder raises `mem_valid` only after seeing `mem_req`, two cycles later, and drops it once the request ends. Requests are driven as one-cycle pulses with their context at a falling edge, so each pulse meets exactly one rising edge. Intruding requests are pulsed in the cycle after acceptance, which lands them inside the busy window the properties watch.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN  = 32;
  localparam int VEC_W = 8;
  localparam int NSRC  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_SHIFT, ST_FETCH, ST_DONE
  } seq_state_t;

  // Source index doubles as priority: higher index wins.
  localparam int SRC_IRQ = 0;
  localparam int SRC_NMI = 1;
  localparam int SRC_BRK = 2;
  localparam int SRC_BUS = 3;

  // Mode-flag push: top two bits kept, rest moved up by ten, low ten cleared.
  function automatic logic [XLEN-1:0] push_status(input logic [XLEN-1:0] s);
    logic [XLEN-1:0] t;
    t = (s & 32'hC000_0000) | ((s << 12) >> 2);
    return t & ~32'h0000_03FF;
  endfunction

  function automatic logic [XLEN-1:0] info_word(input logic [VEC_W-1:0] v);
    return {16'h0000, v, 8'h00};
  endfunction

  function automatic logic [XLEN-1:0] table_addr(input logic [XLEN-1:0] base,
                                                 input logic [VEC_W-1:0] v);
    return base + ({{(XLEN-VEC_W){1'b0}}, v} << 2);
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         hit
);
  always_comb begin
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
  assign hit = |req;
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mem_valid,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_SAVE;
      ST_SAVE:  nxt = ST_SHIFT;
      ST_SHIFT: nxt = ST_FETCH;
      ST_FETCH: if (mem_valid) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int IEN_BIT    = 4,
  parameter int USER_BIT   = 8,
  parameter int NMIEN_BIT  = 9,
  parameter int DSLOT_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_irq,
  input  logic             req_nmi,
  input  logic             req_brk,
  input  logic             req_bus,
  input  logic             irq_lock,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic             in_dslot,
  input  logic [XLEN-1:0]  cur_status,
  input  logic [XLEN-1:0]  cur_sp,
  input  logic [XLEN-1:0]  kern_sp,
  input  logic [XLEN-1:0]  vec_base,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  input  logic             mem_valid,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [NSRC-1:0]  ack,
  output logic [XLEN-1:0]  ret_addr,
  output logic             erp_we,
  output logic             nrp_we,
  output logic [XLEN-1:0]  exc_info,
  output logic             exc_info_we,
  output logic             dslot_clr,
  output logic             stack_we,
  output logic [XLEN-1:0]  usp_out,
  output logic [XLEN-1:0]  sp_out,
  output logic [XLEN-1:0]  status_out,
  output logic             status_we,
  output logic [XLEN-1:0]  pc_out,
  output logic             pc_we,
  output logic             done,
  output logic             recursive_fault
);
  localparam logic [XLEN-1:0] DS_STEP  = XLEN'(DSLOT_STEP);
  localparam logic [XLEN-1:0] NMI_MASK = XLEN'(1) << NMIEN_BIT;

  seq_state_t      state;
  logic [NSRC-1:0] req_vec, elig, grant;
  logic            hit, busy, accept;

  // Captured context
  logic [NSRC-1:0]  src_q;
  logic [VEC_W-1:0] vec_q, vec_sel;
  logic [XLEN-1:0]  pc_q, stat_q, sp_q, ksp_q, base_q, fetch_q;
  logic             ds_q;

  assign req_vec = {req_bus, req_brk, req_nmi, req_irq};
  assign elig    = {1'b1, 1'b1, cur_status[NMIEN_BIT],
                    cur_status[IEN_BIT] & ~irq_lock};

  exc_arbiter #(.N(NSRC)) u_arb (
    .req   (req_vec & elig),
    .grant (grant),
    .hit   (hit)
  );

  exc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (hit),
    .mem_valid (mem_valid),
    .state     (state)
  );

  assign busy   = (state != ST_IDLE);
  assign accept = hit && !busy;

  always_comb begin
    vec_sel = '0;
    if (grant[SRC_BUS])      vec_sel = fault_vec;
    else if (grant[SRC_BRK]) vec_sel = trap_vec;
    else if (grant[SRC_IRQ]) vec_sel = irq_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      vec_q  <= '0;
      pc_q   <= '0;
      stat_q <= '0;
      sp_q   <= '0;
      ksp_q  <= '0;
      base_q <= '0;
      ds_q   <= 1'b0;
    end else if (accept) begin
      src_q  <= grant;
      vec_q  <= vec_sel;
      pc_q   <= cur_pc;
      stat_q <= cur_status;
      sp_q   <= cur_sp;
      ksp_q  <= kern_sp;
      base_q <= vec_base;
      ds_q   <= in_dslot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  fetch_q <= '0;
    else if (state == ST_FETCH && mem_valid)  fetch_q <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                                recursive_fault <= 1'b0;
    else if (busy && src_q[SRC_BUS] && req_bus) recursive_fault <= 1'b1;
  end

  logic in_save, in_shift;
  assign in_save  = (state == ST_SAVE);
  assign in_shift = (state == ST_SHIFT);

  assign ack         = in_save ? src_q : '0;
  assign ret_addr    = pc_q - (ds_q ? DS_STEP : '0);
  assign erp_we      = in_save & ~src_q[SRC_NMI];
  assign nrp_we      = in_save &  src_q[SRC_NMI];
  assign exc_info    = info_word(vec_q);
  assign exc_info_we = in_save;
  assign dslot_clr   = in_save & ds_q;

  assign status_we  = in_shift;
  assign status_out = push_status(src_q[SRC_NMI] ? (stat_q & ~NMI_MASK) : stat_q);
  assign stack_we   = in_shift & stat_q[USER_BIT];
  assign usp_out    = sp_q;
  assign sp_out     = ksp_q;

  assign mem_req  = (state == ST_FETCH);
  assign mem_addr = table_addr(base_q, vec_q);

  assign pc_we  = (state == ST_DONE);
  assign done   = (state == ST_DONE);
  assign pc_out = fetch_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] ack,
  input logic            erp_we,
  input logic            nrp_we,
  input logic [XLEN-1:0] exc_info,
  input logic            exc_info_we,
  input logic            status_we,
  input logic [XLEN-1:0] status_out,
  input logic            stack_we,
  input logic            mem_req,
  input logic            mem_valid,
  input logic [XLEN-1:0] mem_addr,
  input logic            pc_we,
  input logic            busy,
  input logic            accept,
  input logic            req_bus,
  input logic            recursive_fault
);
  assert_ack_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));

  assert_ack_follows_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (ack != '0) |-> $past(accept));

  assert_single_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (ack != '0) |=> (ack == '0));

  assert_info_format_R3: assert property (@(posedge clk) disable iff (rst)
    exc_info_we |-> (exc_info[31:16] == 16'h0 && exc_info[7:0] == 8'h0));

  assert_one_return_reg_R4: assert property (@(posedge clk) disable iff (rst)
    exc_info_we |-> (erp_we ^ nrp_we));

  assert_nmi_return_R4: assert property (@(posedge clk) disable iff (rst)
    ack[1] |-> (nrp_we && !erp_we));

  assert_swap_in_shift_R6: assert property (@(posedge clk) disable iff (rst)
    stack_we |-> status_we);

  assert_status_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
    status_we |-> (status_out[9:0] == 10'h0));

  assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  assert_pc_after_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> $past(mem_req && mem_valid));

  assert_recursive_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(recursive_fault) |-> $past(busy && req_bus));
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .ack             (ack),
  .erp_we          (erp_we),
  .nrp_we          (nrp_we),
  .exc_info        (exc_info),
  .exc_info_we     (exc_info_we),
  .status_we       (status_we),
  .status_out      (status_out),
  .stack_we        (stack_we),
  .mem_req         (mem_req),
  .mem_valid       (mem_valid),
  .mem_addr        (mem_addr),
  .pc_we           (pc_we),
  .busy            (busy),
  .accept          (accept),
  .req_bus         (req_bus),
  .recursive_fault (recursive_fault)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic req_irq = 0, req_nmi = 0, req_brk = 0, req_bus = 0, irq_lock = 0;
  logic [7:0]  irq_vec = 0, trap_vec = 0, fault_vec = 0;
  logic [31:0] cur_pc = 0, cur_status = 0, cur_sp = 0, kern_sp = 0, vec_base = 0;
  logic        in_dslot = 0;
  logic        mem_req, mem_valid = 0;
  logic [31:0] mem_addr, mem_rdata;
  logic [3:0]  ack;
  logic [31:0] ret_addr, exc_info, usp_out, sp_out, status_out, pc_out;
  logic erp_we, nrp_we, exc_info_we, dslot_clr, stack_we, status_we, pc_we, done;
  logic recursive_fault;

  assign mem_rdata = ~mem_addr;

  exc_entry_seq u_exc_entry_seq (.*);

  typedef struct {
    logic [3:0]  ack;
    logic        nmi;
    logic [31:0] ret;
    logic [31:0] info;
    logic        ds;
    logic        swap;
    logic [31:0] usp, sp, status, addr, pc;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0, nacks = 0, ndone = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: valid two cycles after the request appears
  int wcnt = 0;
  always @(negedge clk) begin
    if (mem_req && !mem_valid) begin
      if (wcnt == 2) begin mem_valid <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end else begin
      mem_valid <= 1'b0;
      wcnt <= 0;
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (ack != 0) begin
        nacks++;
        if (sb.size() == 0) check(0, "R9 unexpected ack", {28'h0, ack}, 0);
        else begin
          check(ack == sb[0].ack, "R1 ack source", {28'h0, ack}, {28'h0, sb[0].ack});
          check(nrp_we == sb[0].nmi && erp_we == !sb[0].nmi, "R4 return register",
                {30'h0, nrp_we, erp_we}, {30'h0, sb[0].nmi, !sb[0].nmi});
          check(ret_addr == sb[0].ret, "R5 return address", ret_addr, sb[0].ret);
          check(exc_info_we && exc_info == sb[0].info, "R3 info word", exc_info, sb[0].info);
          check(dslot_clr == sb[0].ds, "R5 dslot clear", {31'h0, dslot_clr}, {31'h0, sb[0].ds});
        end
      end
      if (status_we && sb.size() != 0) begin
        check(status_out == sb[0].status, "R7 status push", status_out, sb[0].status);
        check(stack_we == sb[0].swap, "R6 swap strobe", {31'h0, stack_we}, {31'h0, sb[0].swap});
        if (sb[0].swap) begin
          check(usp_out == sb[0].usp, "R6 user sp", usp_out, sb[0].usp);
          check(sp_out == sb[0].sp, "R6 kernel sp", sp_out, sb[0].sp);
        end
      end
      if (mem_req && sb.size() != 0)
        check(mem_addr == sb[0].addr, "R8 fetch address", mem_addr, sb[0].addr);
      if (pc_we && sb.size() != 0) begin
        check(done && pc_out == sb[0].pc, "R8 handler pc", pc_out, sb[0].pc);
        void'(sb.pop_front());
        ndone++;
      end
    end
  end

  // Driver: reqs = {bus, brk, nmi, irq}; intr pulsed one cycle into the sequence
  task automatic fire(input logic [3:0] reqs, input logic [3:0] intr, input logic lock,
                      input logic [31:0] st, input logic [31:0] pc, input logic ds,
                      input logic [31:0] sp, input logic [31:0] ksp, input logic [31:0] base,
                      input logic [7:0] iv, input logic [7:0] tv, input logic [7:0] fv);
    exp_t e;
    logic [7:0] v;
    logic [31:0] s;
    bit take = 1;
    int acks0 = nacks;
    if (reqs[3])                        begin e.ack = 4'b1000; v = fv; end
    else if (reqs[2])                   begin e.ack = 4'b0100; v = tv; end
    else if (reqs[1] && st[9])          begin e.ack = 4'b0010; v = 8'h00; end
    else if (reqs[0] && st[4] && !lock) begin e.ack = 4'b0001; v = iv; end
    else begin take = 0; e.ack = 0; v = 0; end
    e.nmi  = (e.ack == 4'b0010);
    e.ret  = pc - (ds ? 32'd2 : 32'd0);
    e.info = {16'h0, v, 8'h0};
    e.ds   = ds;
    e.swap = st[8];
    e.usp  = sp;
    e.sp   = ksp;
    s = e.nmi ? (st & ~32'h200) : st;
    e.status = {s[31:30], s[19:0], 10'h0};
    e.addr = base + 32'(v) * 4;
    e.pc   = ~e.addr;
    if (take) sb.push_back(e);
    @(negedge clk);
    {req_bus, req_brk, req_nmi, req_irq} = reqs;
    irq_lock = lock; cur_status = st; cur_pc = pc; in_dslot = ds;
    cur_sp = sp; kern_sp = ksp; vec_base = base;
    irq_vec = iv; trap_vec = tv; fault_vec = fv;
    @(negedge clk);
    {req_bus, req_brk, req_nmi, req_irq} = intr;
    @(negedge clk);
    {req_bus, req_brk, req_nmi, req_irq} = 4'b0;
    if (take) begin
      int target = ndone + 1;
      while (ndone < target) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    check(nacks == acks0 + (take ? 1 : 0), take ? "R9 single acceptance" : "R2 masked request",
          32'(nacks - acks0), take ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ack == 0 && mem_req == 0 && done == 0 && recursive_fault == 0 &&
          erp_we == 0 && status_we == 0 && pc_we == 0, "R11 in reset",
          {ack, 28'h0}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ack == 0 && mem_req == 0 && done == 0 && recursive_fault == 0,
          "R11 after reset", {ack, 27'h0, recursive_fault}, 0);

    // R1/R3/R8: lone interrupt, kernel mode, no delay slot
    fire(4'b0001, 0, 0, 32'h0000_0010, 32'h1000_0040, 0, 32'hA000, 32'hB000,
         32'h0800_0000, 8'h21, 8'h05, 8'h07);
    // R2: interrupt locked, then interrupt disabled
    fire(4'b0001, 0, 1, 32'h0000_0010, 32'h1000_0040, 0, 0, 0, 0, 8'h21, 0, 0);
    fire(4'b0001, 0, 0, 32'h0000_0000, 32'h1000_0040, 0, 0, 0, 0, 8'h21, 0, 0);
    // R4/R5/R6/R7: NMI in user mode, delay slot
    fire(4'b0010, 0, 0, 32'hC00F_F3FF, 32'h2000_0100, 1, 32'h7FF0, 32'h8FF0,
         32'h0000_1000, 8'h33, 8'h44, 8'h55);
    // R2: NMI with enable clear
    fire(4'b0010, 0, 0, 32'hFFFF_FDFF, 32'h2000_0100, 0, 0, 0, 0, 0, 0, 0);
    // R1: priority
    fire(4'b0111, 0, 0, 32'h0000_0310, 32'h3000_0008, 1, 32'h11, 32'h22,
         32'h0004_0000, 8'h01, 8'hFF, 8'h02);
    fire(4'b1111, 0, 0, 32'h0000_0310, 32'h3000_0008, 0, 32'h11, 32'h22,
         32'h0004_0000, 8'h01, 8'hFF, 8'h80);
    fire(4'b0011, 0, 0, 32'h5A5A_A310, 32'h3000_000C, 0, 32'h11, 32'h22,
         32'h0004_0000, 8'h01, 8'h03, 8'h80);
    // R9/R10: interrupt intruding into a break does not count as recursive
    fire(4'b0100, 4'b0001, 0, 32'h0000_0110, 32'h4000_0000, 0, 32'h99, 32'h88,
         32'h0010_0000, 8'h09, 8'h0A, 8'h0B);
    check(recursive_fault == 0, "R10 no recursive flag", {31'h0, recursive_fault}, 0);
    // R10: bus fault intruding into a bus-fault entry
    fire(4'b1000, 4'b1000, 0, 32'h0000_0100, 32'h4000_0020, 0, 32'h99, 32'h88,
         32'h0010_0000, 8'h09, 8'h0A, 8'hFE);
    check(recursive_fault == 1, "R10 recursive flag set", {31'h0, recursive_fault}, 1);
    repeat (4) @(negedge clk);
    check(recursive_fault == 1, "R10 flag sticky", {31'h0, recursive_fault}, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(recursive_fault == 0, "R10 R11 cleared by reset", {31'h0, recursive_fault}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule